// File: doc/BRIEF.md
# Exclusive Access Monitor with Byte Lanes

This block sits between one processor-side request port and a word-wide memory array. It serves ordinary loads and stores in byte, halfword and word sizes. It also serves exclusive load and exclusive store requests. Sub-word data is placed on little-endian byte lanes. Write strobes enable only the bytes that a request addresses. Each request gets a registered response one clock after it is accepted.

A local monitor records one reservation, holding both the address and the size of the last aligned exclusive load. An exclusive store commits only when it hits that same reservation. It reports 0 on success and 1 on failure, and it always returns the monitor to the open state. The reservation is also dropped by an ordinary store to the reserved word or by a dedicated clear input. Software can therefore build read-modify-write sequences and semaphores on top of the array.

Top module: `excl_mon_top`

## Requirements
- R1: After reset, `rsp_valid` is 0 and the monitor is open, so an exclusive store issued before any exclusive load fails with status 1.
- R2: Every request with `req_valid`=1 produces `rsp_valid`=1 on the next clock. A load returns the selected bytes zero-extended to 32 bits. The byte at address 4k+i appears on bits [8i+7:8i] of word k (little-endian).
- R3: A store writes only the addressed bytes. Size 0 (byte) writes `req_wdata[7:0]`, size 1 (halfword) writes `req_wdata[15:0]` and size 2 (word) writes all 32 bits. All other bytes of the word keep their values.
- R4: A request is misaligned if its size is 3, if it is a halfword with address bit 0 set, or if it is a word with address bits [1:0] not zero. A misaligned request returns `rsp_err`=1 and `rsp_rdata`=0, and it writes nothing. A misaligned exclusive load leaves the monitor unchanged.
- R5: An aligned exclusive load returns the same data as an ordinary load. It also makes the monitor exclusive, recording the load's address and size.
- R6: An exclusive store whose address and size both equal the reservation writes memory like a store and returns status 0.
- R7: An exclusive store with no reservation, or with a different address or size, returns status 1 and leaves memory unchanged. A misaligned exclusive store also returns status 1.
- R8: Every exclusive store returns the monitor to the open state, whether it succeeds or fails, so a second exclusive store fails.
- R9: An aligned ordinary store to any byte of the reserved word clears the reservation. A store to a different word does not clear it.
- R10: `clr_excl`=1 clears the reservation. If it is high in the same cycle as an exclusive load, the monitor ends open. If it is high in the same cycle as an exclusive store, that store fails.
- R11: An ordinary load leaves the reservation intact.
- R12: `rsp_status` is 0 for every response except a failed exclusive store, and `rsp_rdata` is 0 for every store response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_excl | input | 1 | Exclusive variant of the access |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| clr_excl | input | 1 | Drop the reservation |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Load data, zero-extended |
| rsp_status | output | 1 | 1 = exclusive store failed |
| rsp_err | output | 1 | Misaligned or illegal-size request |

## Verification
The bench builds the block with the default `ADDR_W` of 10, which gives a 256-word array. With that size, reservations and stores can fall into the same word as the reservation or into neighbouring words. This exercises the word-index comparison that decides whether an ordinary store clears the monitor. The default also lets every byte-lane position and every misaligned offset of each size be reached at a handful of addresses. A byte-level model in the bench predicts the load data.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic [WORD_W-1:0] rdata;
    logic              status;
    logic              err;
  } rsp_t;
endpackage

// File: rtl/excl_mon_lane.sv
module excl_mon_lane
  import excl_mon_pkg::*;
(
  input  logic [1:0]        off,
  input  logic [1:0]        size,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] rword,
  output logic              misal,
  output logic [LANES-1:0]  be,
  output logic [WORD_W-1:0] wlane,
  output logic [WORD_W-1:0] rsel
);
  acc_size_e sz;
  assign sz = acc_size_e'(size);

  always_comb begin
    unique case (sz)
      SZ_BYTE: misal = 1'b0;
      SZ_HALF: misal = off[0];
      SZ_WORD: misal = (off != 2'd0);
      default: misal = 1'b1;
    endcase
  end

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      always_comb begin
        unique case (sz)
          SZ_BYTE: begin
            be[i] = (off == 2'(i));
            wlane[i*BYTE_W +: BYTE_W] = wdata[BYTE_W-1:0];
          end
          SZ_HALF: begin
            be[i] = (off[1] == 1'(i / 2));
            wlane[i*BYTE_W +: BYTE_W] = wdata[(i % 2)*BYTE_W +: BYTE_W];
          end
          SZ_WORD: begin
            be[i] = 1'b1;
            wlane[i*BYTE_W +: BYTE_W] = wdata[i*BYTE_W +: BYTE_W];
          end
          default: begin
            be[i] = 1'b0;
            wlane[i*BYTE_W +: BYTE_W] = '0;
          end
        endcase
      end
    end
  endgenerate

  always_comb begin
    rsel = '0;
    unique case (sz)
      SZ_BYTE: rsel[BYTE_W-1:0]   = rword[off*BYTE_W +: BYTE_W];
      SZ_HALF: rsel[2*BYTE_W-1:0] = rword[off[1]*2*BYTE_W +: 2*BYTE_W];
      SZ_WORD: rsel               = rword;
      default: rsel               = '0;
    endcase
  end
endmodule

// File: rtl/excl_mon_mem.sv
module excl_mon_mem
  import excl_mon_pkg::*;
#(
  parameter int IDX_W = 8,
  localparam int WORDS = 1 << IDX_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  be,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wlane,
  output logic [WORD_W-1:0] rword
);
  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_bank
      logic [BYTE_W-1:0] bank [WORDS];
      always_ff @(posedge clk) begin
        if (be[i]) bank[idx] <= wlane[i*BYTE_W +: BYTE_W];
      end
      assign rword[i*BYTE_W +: BYTE_W] = bank[idx];
    end
  endgenerate
endmodule

// File: rtl/excl_mon_resv.sv
module excl_mon_resv #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic [1:0]        set_size,
  input  logic              clr_en,
  output logic              held,
  output logic [ADDR_W-1:0] resv_addr,
  output logic [1:0]        resv_size
);
  logic              held_d;
  logic [ADDR_W-1:0] addr_d;
  logic [1:0]        size_d;
  logic              tag_en;

  always_comb begin
    held_d = held;
    if (set_en) held_d = 1'b1;
    if (clr_en) held_d = 1'b0;
    tag_en = set_en & ~clr_en;
    addr_d = set_addr;
    size_d = set_size;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= held_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resv_addr <= '0;
      resv_size <= '0;
    end else if (tag_en) begin
      resv_addr <= addr_d;
      resv_size <= size_d;
    end
  end
endmodule

// File: rtl/excl_mon_top.sv
module excl_mon_top
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_excl,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic              clr_excl,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_status,
  output logic              rsp_err
);
  logic              misal;
  logic [LANES-1:0]  lane_be;
  logic [LANES-1:0]  mem_be;
  logic [WORD_W-1:0] wlane;
  logic [WORD_W-1:0] rword;
  logic [WORD_W-1:0] rsel;
  logic              resv_held;
  logic [ADDR_W-1:0] resv_addr;
  logic [1:0]        resv_size;

  logic is_ld, is_st, is_ldx, is_stx;
  logic hit_resv, hit_word, do_write, set_en, clr_en;
  rsp_t rsp_d, rsp_q;

  excl_mon_lane u_lane (
    .off   (req_addr[1:0]),
    .size  (req_size),
    .wdata (req_wdata),
    .rword (rword),
    .misal (misal),
    .be    (lane_be),
    .wlane (wlane),
    .rsel  (rsel)
  );

  excl_mon_mem #(.IDX_W(IDX_W)) u_mem (
    .clk   (clk),
    .be    (mem_be),
    .idx   (req_addr[ADDR_W-1:2]),
    .wlane (wlane),
    .rword (rword)
  );

  excl_mon_resv #(.ADDR_W(ADDR_W)) u_resv (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (set_en),
    .set_addr  (req_addr),
    .set_size  (req_size),
    .clr_en    (clr_en),
    .held      (resv_held),
    .resv_addr (resv_addr),
    .resv_size (resv_size)
  );

  always_comb begin
    is_ld  = req_valid & ~req_write & ~req_excl;
    is_ldx = req_valid & ~req_write &  req_excl;
    is_st  = req_valid &  req_write & ~req_excl;
    is_stx = req_valid &  req_write &  req_excl;

    hit_resv = resv_held & ~clr_excl & (resv_addr == req_addr) &
               (resv_size == req_size) & ~misal;
    hit_word = (resv_addr[ADDR_W-1:2] == req_addr[ADDR_W-1:2]);

    do_write = (is_st & ~misal) | (is_stx & hit_resv);
    mem_be   = lane_be & {LANES{do_write}};

    set_en = is_ldx & ~misal;
    clr_en = clr_excl | is_stx | (is_st & ~misal & hit_word);
  end

  always_comb begin
    rsp_d.rdata  = ((is_ld | is_ldx) & ~misal) ? rsel : '0;
    rsp_d.status = is_stx & ~hit_resv;
    rsp_d.err    = req_valid & misal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rsp_q <= '0;
    else if (req_valid) rsp_q <= rsp_d;
    else                rsp_q <= '0;
  end

  assign rsp_rdata  = rsp_q.rdata;
  assign rsp_status = rsp_q.status;
  assign rsp_err    = rsp_q.err;
endmodule

// File: rtl/excl_mon_chk.sv
module excl_mon_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_excl,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] req_addr,
  input logic              clr_excl,
  input logic              rsp_valid,
  input logic              rsp_status,
  input logic              rsp_err,
  input logic              resv_held,
  input logic [3:0]        mem_be
);
  logic port_misal;
  assign port_misal = (req_size == 2'd3) ||
                      (req_size == 2'd1 && req_addr[0]) ||
                      (req_size == 2'd2 && req_addr[1:0] != 2'd0);

  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R4
  misal_flags_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && port_misal) |=> rsp_err);

  // R4
  misal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && port_misal) |-> (mem_be == 4'b0000));

  // R7
  open_stx_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_excl && !resv_held) |-> (mem_be == 4'b0000));

  // R7
  open_stx_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_excl && !resv_held) |=> rsp_status);

  // R8
  stx_opens_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_excl) |=> !resv_held);

  // R10
  clr_opens_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_excl |=> !resv_held);

  // R5
  ldx_arms_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_excl && !port_misal && !clr_excl) |=> resv_held);

  // R12
  status_only_stx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && req_excl) |=> !rsp_status);
endmodule

bind excl_mon_top excl_mon_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_excl   (req_excl),
  .req_size   (req_size),
  .req_addr   (req_addr),
  .clr_excl   (clr_excl),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .rsp_err    (rsp_err),
  .resv_held  (resv_held),
  .mem_be     (mem_be)
);

// File: tb/excl_mon_top_tb_top.sv
module excl_mon_top_tb_top;
  localparam int ADDR_W = 10;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_write;
  logic              req_excl;
  logic [1:0]        req_size;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_wdata;
  logic              clr_excl;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic              rsp_status;
  logic              rsp_err;

  excl_mon_top #(.ADDR_W(ADDR_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_excl   (req_excl),
    .req_size   (req_size),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .clr_excl   (clr_excl),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_status (rsp_status),
    .rsp_err    (rsp_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [31:0] rdata;
    logic        status;
    logic        err;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [7:0]  mdl [1 << ADDR_W];
  int          n_chk;
  int          n_bad;
  bit          done;

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Driver: one request per call, expected item pushed to the scoreboard.
  task automatic op(input bit wr, input bit ex, input logic [1:0] sz,
                    input int addr, input logic [31:0] wd, input bit clr,
                    input bit exp_st, input bit exp_err, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_excl = ex; req_size = sz;
    req_addr = ADDR_W'(addr); req_wdata = wd; clr_excl = clr;
    e.rdata = '0; e.status = exp_st; e.err = exp_err; e.tag = tag;
    if (!wr && !exp_err) begin
      case (sz)
        2'd0: e.rdata = {24'h0, mdl[addr]};
        2'd1: e.rdata = {16'h0, mdl[addr+1], mdl[addr]};
        default: e.rdata = {mdl[addr+3], mdl[addr+2], mdl[addr+1], mdl[addr]};
      endcase
    end
    if (wr && !exp_err && !(ex && exp_st)) begin
      mdl[addr] = wd[7:0];
      if (sz != 2'd0) mdl[addr+1] = wd[15:8];
      if (sz == 2'd2) begin
        mdl[addr+2] = wd[23:16];
        mdl[addr+3] = wd[31:24];
      end
    end
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_excl = 1'b0; clr_excl = 1'b0;
  endtask

  task automatic clr_only();
    @(negedge clk);
    clr_excl = 1'b1;
    @(negedge clk);
    clr_excl = 1'b0;
  endtask

  // Monitor: pops and compares each response.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && !done) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2 unexpected response: actual valid=1 expected valid=0");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (rsp_rdata !== e.rdata || rsp_status !== e.status || rsp_err !== e.err) begin
          n_bad++;
          $display("FAIL %s: actual rdata=%h st=%b err=%b expected rdata=%h st=%b err=%b",
                   e.tag, rsp_rdata, rsp_status, rsp_err, e.rdata, e.status, e.err);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_excl = 1'b0;
    req_size = 2'd0; req_addr = '0; req_wdata = '0; clr_excl = 1'b0;
    for (int i = 0; i < (1 << ADDR_W); i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    n_chk++;
    if (rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset valid: actual=%b expected=0", rsp_valid);
    end
    // R1: monitor open after reset
    op(1, 1, 2'd2, 'h10, 32'hDEAD0000, 0, 1, 0, "R1 stx after reset");
    // R3 word stores
    op(1, 0, 2'd2, 'h00, 32'h44332211, 0, 0, 0, "R3 st w0");
    op(1, 0, 2'd2, 'h04, 32'hA5B6C7D8, 0, 0, 0, "R3 st w1");
    op(1, 0, 2'd2, 'h10, 32'h00000000, 0, 0, 0, "R3 st w4");
    op(1, 0, 2'd2, 'h20, 32'hCAFEF00D, 0, 0, 0, "R3 st w8");
    // R2 little-endian loads
    for (int i = 0; i < 4; i++) op(0, 0, 2'd0, i, '0, 0, 0, 0, "R2 byte ld");
    op(0, 0, 2'd1, 'h00, '0, 0, 0, 0, "R2 half ld lo");
    op(0, 0, 2'd1, 'h02, '0, 0, 0, 0, "R2 half ld hi");
    op(0, 0, 2'd2, 'h04, '0, 0, 0, 0, "R2 word ld");
    // R3 partial writes
    op(1, 0, 2'd0, 'h05, 32'hFFFFFFEE, 0, 0, 0, "R3 byte st");
    op(0, 0, 2'd2, 'h04, '0, 0, 0, 0, "R3 after byte st");
    op(1, 0, 2'd1, 'h06, 32'hFFFF1234, 0, 0, 0, "R3 half st");
    op(0, 0, 2'd2, 'h04, '0, 0, 0, 0, "R3 after half st");
    // R4 misalignment
    op(0, 0, 2'd1, 'h01, '0, 0, 0, 1, "R4 half ld misal");
    op(1, 0, 2'd2, 'h02, 32'h99999999, 0, 0, 1, "R4 word st misal");
    op(1, 0, 2'd3, 'h00, 32'h77777777, 0, 0, 1, "R4 size3 st");
    op(0, 0, 2'd2, 'h00, '0, 0, 0, 0, "R4 mem unchanged");
    // R5 R6 R8
    op(0, 1, 2'd2, 'h10, '0, 0, 0, 0, "R5 ldx word");
    op(1, 1, 2'd2, 'h10, 32'h11112222, 0, 0, 0, "R6 stx word ok");
    op(0, 0, 2'd2, 'h10, '0, 0, 0, 0, "R6 readback");
    op(1, 1, 2'd2, 'h10, 32'h33334444, 0, 1, 0, "R8 second stx fails");
    op(0, 0, 2'd2, 'h10, '0, 0, 0, 0, "R8 mem unchanged");
    // R7 size / address mismatch
    op(0, 1, 2'd0, 'h11, '0, 0, 0, 0, "R5 ldx byte");
    op(1, 1, 2'd1, 'h10, 32'h5555, 0, 1, 0, "R7 size mismatch");
    op(0, 1, 2'd0, 'h11, '0, 0, 0, 0, "R5 ldx byte again");
    op(1, 1, 2'd0, 'h12, 32'h66, 0, 1, 0, "R7 addr mismatch");
    op(0, 0, 2'd2, 'h10, '0, 0, 0, 0, "R7 mem unchanged");
    op(0, 1, 2'd0, 'h11, '0, 0, 0, 0, "R5 ldx byte 3rd");
    op(1, 1, 2'd0, 'h11, 32'h7F, 0, 0, 0, "R6 stx byte ok");
    op(0, 0, 2'd2, 'h10, '0, 0, 0, 0, "R6 byte readback");
    // R9
    op(0, 1, 2'd1, 'h12, '0, 0, 0, 0, "R9 ldx half");
    op(1, 0, 2'd0, 'h10, 32'hAB, 0, 0, 0, "R9 st same word");
    op(1, 1, 2'd1, 'h12, 32'hBEEF, 0, 1, 0, "R9 stx after clear");
    op(0, 1, 2'd2, 'h20, '0, 0, 0, 0, "R9 ldx w8");
    op(1, 0, 2'd0, 'h04, 32'h01, 0, 0, 0, "R9 st other word");
    op(1, 1, 2'd2, 'h20, 32'h0BADF00D, 0, 0, 0, "R9 stx survives");
    // R11
    op(0, 1, 2'd2, 'h20, '0, 0, 0, 0, "R11 ldx");
    op(0, 0, 2'd2, 'h00, '0, 0, 0, 0, "R11 plain ld");
    op(1, 1, 2'd2, 'h20, 32'h12121212, 0, 0, 0, "R11 stx ok");
    // R10
    op(0, 1, 2'd2, 'h20, '0, 0, 0, 0, "R10 ldx");
    clr_only();
    op(1, 1, 2'd2, 'h20, 32'h34343434, 0, 1, 0, "R10 stx after clr");
    op(0, 1, 2'd2, 'h20, '0, 1, 0, 0, "R10 ldx with clr");
    op(1, 1, 2'd2, 'h20, 32'h56565656, 0, 1, 0, "R10 clr wins");
    op(0, 1, 2'd2, 'h20, '0, 0, 0, 0, "R10 ldx");
    op(1, 1, 2'd2, 'h20, 32'h78787878, 1, 1, 0, "R10 stx with clr");
    // R4 misaligned ldx keeps monitor, misaligned stx fails
    op(0, 1, 2'd2, 'h20, '0, 0, 0, 0, "R4 ldx");
    op(0, 1, 2'd1, 'h21, '0, 0, 0, 1, "R4 ldx misal");
    op(1, 1, 2'd2, 'h20, 32'h9A9A9A9A, 0, 0, 0, "R4 monitor kept");
    op(1, 1, 2'd2, 'h22, 32'h1, 0, 1, 1, "R7 stx misal");
    op(0, 0, 2'd2, 'h20, '0, 0, 0, 0, "R12 final readback");
    repeat (4) @(negedge clk);
    n_chk++;
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 missing responses: actual=%0d expected=0", sb_q.size());
    end
    report();
  end
endmodule